// File: doc/BRIEF.md
# LED Pattern Sequencer

This block moves a lit pattern across eight LEDs. A free-running prescaler provides three slow step rates. Two switch bits pick one of those rates. Each rising edge of the chosen rate moves a 3-bit position counter by one place. The position is then shown on the LEDs in one of two ways: a single lit LED at the position, or a mirrored pair of LEDs that closes in from both ends.

A third switch bit chooses between those two displays. A fourth switch bit turns on automatic reversal, so the position sweeps back and forth between the two ends. When reversal is off, the position only counts upward and wraps. An external brightness strobe, usually a PWM signal, gates both decoders. While the strobe is low every LED is dark, so the strobe's duty cycle sets how bright the LEDs look.

The LED bus is active low. Reset is asynchronous and active low. Reset is also held for as long as the clock-lock input is low.

Top module: `led_pattern_seq`

## Requirements
- R1: While `rst_ni` is low, or `pll_locked_i` is low, the position is 0 and the direction is up. With mode 0 and the strobe high, `led_n_o` is then 8'hFE.
- R2: `sw_i[3:2]` picks the step tap from the prescaler count. Code 0 picks bit TAP_SLOW, code 1 picks bit TAP_MID and code 2 picks bit TAP_FAST. Code 3 repeats bit TAP_SLOW. The defaults are bits 21, 20 and 19 of a 22-bit count. A tap at bit k gives one step every 2^(k+1) clock cycles.
- R3: The position changes exactly once for each rising edge of the selected tap. The change appears on the clock edge that follows the tap's rise.
- R4: Between steps, the position and the LED outputs hold still.
- R5: With `sw_i[1]` = 1, the position sweeps back and forth. It turns downward when it reaches 7 and upward when it reaches 0, so the sequence is 0,1,..,7,6,..,0,1 and so on.
- R6: With `sw_i[1]` = 0, each step adds 1 and 7 wraps to 0. This holds even if the sweep was moving down before reversal was switched off.
- R7: In mode 0 (`sw_i[0]` = 0) with the strobe high, only `led_n_o[pos]` is low.
- R8: In mode 1 (`sw_i[0]` = 1) with the strobe high, let k = pos[2:1]. Then only `led_n_o[k]` and `led_n_o[7-k]` are low.
- R9: While `strobe_i` is low, `led_n_o` is 8'hFF in both modes.
- R10: The mode bit acts combinationally. The LED bus switches display in the same cycle and the position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_locked_i | input | 1 | Clock lock; holds the block in reset while low |
| sw_i | input | 4 | [0] display mode, [1] auto reversal, [3:2] speed select |
| strobe_i | input | 1 | Brightness strobe, active high, gates both decoders |
| led_n_o | output | 8 | LED drive, active low |

## Verification
The step-spacing and single-move properties assume the selected tap is at least bit 1 of the prescaler, so a tap can never rise on two cycles in a row. The properties also assume the switches and the strobe are synchronous to `clk_i`. The bench meets these by driving every input at the falling clock edge. It also shrinks the prescaler to taps 5, 4 and 3. After changing the speed select, the bench ignores the first two position changes before it measures any interval. This allows for the one extra step that can occur when the tap changes.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  localparam int LED_N = 8;
  localparam int POS_W = $clog2(LED_N);

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_MIRROR = 1'b1
  } led_mode_e;
endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int CNT_W    = 22,
  parameter int TAP_SLOW = 21,
  parameter int TAP_MID  = 20,
  parameter int TAP_FAST = 19
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tap, tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tap_q <= tap;
    end
  end

  // code 3 falls back to the slowest tap
  always_comb begin
    case (sel_i)
      2'd1:    tap = cnt_q[TAP_MID];
      2'd2:    tap = cnt_q[TAP_FAST];
      default: tap = cnt_q[TAP_SLOW];
    endcase
  end

  assign step_o = tap & ~tap_q;

  p_step_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/led_pos_counter.sv
module led_pos_counter
  import led_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic auto_i,
  output pos_t pos_o
);
  localparam pos_t POS_MAX = pos_t'(LED_N - 1);

  pos_t pos_q, pos_nxt;
  logic up_q, up_eff;

  always_comb begin
    up_eff = 1'b1;
    if (auto_i) begin
      if (pos_q == POS_MAX)   up_eff = 1'b0;
      else if (pos_q == '0)   up_eff = 1'b1;
      else                    up_eff = up_q;
    end
    pos_nxt = up_eff ? pos_q + 1'b1 : pos_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      up_q  <= 1'b1;
    end else begin
      if (step_i) pos_q <= pos_nxt;
      if (!auto_i)     up_q <= 1'b1;
      else if (step_i) up_q <= up_eff;
    end
  end

  assign pos_o = pos_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_o));
  p_moves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pos_o != $past(pos_o));
  p_count_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !auto_i) |=> pos_o == pos_t'($past(pos_o) + 1'b1));
  p_turn_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && auto_i && pos_o == POS_MAX) |=> pos_o == POS_MAX - 1'b1);
  p_turn_bot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && auto_i && pos_o == '0) |=> pos_o == pos_t'(1));
endmodule

// File: rtl/led_pattern_dec.sv
module led_pattern_dec
  import led_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pos_t             pos_i,
  input  led_mode_e        mode_i,
  input  logic             strobe_i,
  output logic [LED_N-1:0] led_n_o
);
  logic [LED_N-1:0] single_n, mirror_n;

  for (genvar i = 0; i < LED_N; i++) begin : g_led
    // mirrored line index: LED i and LED N-1-i share a line
    localparam int LINE = (i < LED_N / 2) ? i : LED_N - 1 - i;
    assign single_n[i] = !(strobe_i && (pos_i == POS_W'(i)));
    assign mirror_n[i] = !(strobe_i && (pos_i[POS_W-1:1] == (POS_W-1)'(LINE)));
  end

  assign led_n_o = (mode_i == MODE_MIRROR) ? mirror_n : single_n;

  p_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |-> &led_n_o);
  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == MODE_SINGLE) |->
      ($countones(~led_n_o) == 1 && !led_n_o[pos_i]));
  p_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == MODE_MIRROR) |-> $countones(~led_n_o) == 2);
endmodule

// File: rtl/led_pattern_seq.sv
module led_pattern_seq
  import led_seq_pkg::*;
#(
  parameter int CNT_W    = 22,
  parameter int TAP_SLOW = 21,
  parameter int TAP_MID  = 20,
  parameter int TAP_FAST = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pll_locked_i,
  input  logic [3:0]       sw_i,
  input  logic             strobe_i,
  output logic [LED_N-1:0] led_n_o
);
  logic arst_n;
  logic step;
  pos_t pos;

  // reset held until the clock source reports lock
  assign arst_n = rst_ni & pll_locked_i;

  led_prescaler #(
    .CNT_W   (CNT_W),
    .TAP_SLOW(TAP_SLOW),
    .TAP_MID (TAP_MID),
    .TAP_FAST(TAP_FAST)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(arst_n),
    .sel_i (sw_i[3:2]),
    .step_o(step)
  );

  led_pos_counter u_pos (
    .clk_i (clk_i),
    .rst_ni(arst_n),
    .step_i(step),
    .auto_i(sw_i[1]),
    .pos_o (pos)
  );

  led_pattern_dec u_dec (
    .clk_i   (clk_i),
    .rst_ni  (arst_n),
    .pos_i   (pos),
    .mode_i  (led_mode_e'(sw_i[0])),
    .strobe_i(strobe_i),
    .led_n_o (led_n_o)
  );
endmodule

// File: tb/led_pattern_seq_tb_top.sv
module led_pattern_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       locked = 1'b1;
  logic [3:0] sw = 4'd0;
  logic       strobe = 1'b1;
  logic [7:0] led;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  led_pattern_seq #(.CNT_W(6), .TAP_SLOW(5), .TAP_MID(4), .TAP_FAST(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pll_locked_i(locked),
    .sw_i(sw), .strobe_i(strobe), .led_n_o(led)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pos_of(input logic [7:0] l);
    int p = -1;
    int z = 0;
    for (int i = 0; i < 8; i++) if (!l[i]) begin z++; p = i; end
    return (z == 1) ? p : -1;
  endfunction

  task automatic wait_change(output int cyc, output logic [7:0] v);
    logic [7:0] s = led;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (led !== s) begin v = led; return; end
      if (cyc > 600) begin
        chk(0, "R3 timeout waiting for step", cyc, 0);
        v = led;
        return;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; locked = 1'b1; sw = 4'd0; strobe = 1'b1;
    repeat (5) @(negedge clk);
    chk(led == 8'hFE, "R1 reset pattern", led, 8'hFE);
    rst_n = 1'b1; locked = 1'b0;
    repeat (100) @(negedge clk);
    chk(led == 8'hFE, "R1 held while unlocked", led, 8'hFE);
    locked = 1'b1;
  endtask

  task automatic t_count_up();
    int c; int p; logic [7:0] v;
    sw = {2'd2, 1'b0, 1'b0};
    wait_change(c, v); wait_change(c, v);
    p = pos_of(led);
    for (int i = 0; i < 10; i++) begin
      wait_change(c, v);
      chk(pos_of(v) == (p + 1) % 8, "R6 count up/wrap", pos_of(v), (p + 1) % 8);
      chk(c == 16, "R3 R4 step interval", c, 16);
      p = (p + 1) % 8;
    end
  endtask

  task automatic t_pingpong();
    int c; int p; int e; bit up; logic [7:0] v;
    sw[1] = 1'b1;
    up = 1'b1;
    p = pos_of(led);
    for (int i = 0; i < 40; i++) begin
      if (p == 7) up = 1'b0;
      else if (p == 0) up = 1'b1;
      e = up ? p + 1 : p - 1;
      wait_change(c, v);
      chk(pos_of(v) == e, "R5 ping-pong sweep", pos_of(v), e);
      p = e;
      if (i >= 20 && !up && p != 0 && p != 7) break;
    end
    sw[1] = 1'b0;
    wait_change(c, v);
    chk(pos_of(v) == (p + 1) % 8, "R6 up after disabling reversal", pos_of(v), (p + 1) % 8);
  endtask

  task automatic t_speed();
    int c; logic [7:0] v;
    int per[4] = '{64, 32, 16, 64};
    for (int s = 0; s < 4; s++) begin
      sw[3:2] = 2'(s);
      wait_change(c, v); wait_change(c, v);
      for (int k = 0; k < 2; k++) begin
        wait_change(c, v);
        chk(c == per[s], $sformatf("R2 interval sel=%0d", s), c, per[s]);
      end
    end
  endtask

  task automatic t_mirror();
    int c; int p; logic [7:0] v; logic [7:0] e;
    sw = {2'd2, 1'b0, 1'b0};
    for (int i = 0; i < 8; i++) begin
      wait_change(c, v);
      p = pos_of(led);
      sw[0] = 1'b1; #1;
      e = 8'hFF; e[p >> 1] = 1'b0; e[7 - (p >> 1)] = 1'b0;
      chk(led == e, "R8 R10 mirrored pair", led, e);
      sw[0] = 1'b0; #1;
      e = 8'hFF; e[p] = 1'b0;
      chk(led == e, "R7 R10 single lit", led, e);
    end
  endtask

  task automatic t_strobe();
    strobe = 1'b0;
    for (int m = 0; m < 2; m++) begin
      sw[0] = m[0];
      for (int i = 0; i < 4; i++) begin
        repeat (10) @(negedge clk);
        chk(led == 8'hFF, "R9 dark while strobe low", led, 8'hFF);
      end
    end
    strobe = 1'b1; #1;
    chk(led != 8'hFF, "R9 lit again with strobe", led, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count_up();
    t_pingpong();
    t_speed();
    t_mirror();
    t_strobe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule